// File: doc/BRIEF.md
# I2C Stalling Target Responder

This block is the target side of an I2C port. It watches the bus for a START, shifts in the address byte and compares its upper seven bits with a programmable own address. When they match it ACKs the address and then handles every following byte on its own. Each significant point in the transfer raises an event: the address match, each byte moved in either direction, and the STOP that ends a matched transfer.

While an event is pending the block can hold SCL low. This gives the local host as long as it needs to decide how to respond. The host answers with a single command word, and that one write does three things: it clears the pending events, sets the ACK policy for the next received byte, and supplies the next byte to send to a reading master. Writing to SCL is done by pulling it low only, so the port connects to an open-drain pad pair.

Top module: `i2c_stall_target`

## Requirements
- R1: After reset, no event is pending (`evt_o` = 0), `irq_o` is low and neither bus line is pulled low.
- R2: An address byte whose upper seven bits equal `own_addr[7:1]`, with `own_addr` nonzero, is ACKed. After the ACK clock the block raises a command event (`evt_o` bit 0). In `stat_o`, bit 2 then holds the R/W bit (1 = master reads) and bit 5 is 0.
- R3: An address that does not match, or any address while `own_addr` is zero, is NACKed and raises no event. The block then ignores the bus until the next START, so a STOP that follows raises no event either.
- R4: While an event is pending and stall (command bit 0) is set, `scl_oe` pulls SCL low after the ACK clock. A command write with bit 6 set clears all events and releases SCL in the next cycle.
- R5: After each byte written by the master, `rx_data_o` holds that byte and a data event (`evt_o` bit 1) is raised.
- R6: A data byte written by the master is ACKed if command bit 3 was set in the most recent command word, and NACKed if it was clear.
- R7: On a master read, the block sends bits [15:8] of the command word that cleared the preceding event, MSB first.
- R8: After each byte read by the master, a data event is raised with `stat_o` bit 3 equal to the master's ACK. A NACK ends the read, and the block stops driving SDA.
- R9: A STOP after a matched START raises a command event with `stat_o` bit 5 set, and does not stretch SCL.
- R10: While command bit 4 (event mask) is set, no event is latched and SCL is never stretched. Address matching and the ACK handshake still take place.
- R11: With stall clear, events are latched and accumulate, but SCL is never stretched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| own_addr_wr | input | 1 | Write strobe for the own address |
| own_addr_d | input | 8 | Own address shifted left by one; zero disables matching |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_d | input | 16 | Command: [15:8] byte to send, 6 clear events, 4 mask, 3 ACK next byte, 0 stall |
| evt_o | output | 2 | Pending events: bit 0 command, bit 1 data |
| stat_o | output | 8 | Status: bit 5 STOP, bit 3 master ACK, bit 2 master reads |
| rx_data_o | output | 8 | Last byte received from the master |
| irq_o | output | 1 | Some event is pending |

## Verification
The main function is exercised with a matched write, in which the ACK policy is flipped between bytes, and a matched read, in which the master ACKs one byte and NACKs the next. Together these separate the ACK decision for the address from the one for the data, and show which command word supplies each transmitted byte. Further patterns use a non-matching address and a zero own address, which separate no-match from disabled and show that the following STOP is silent. Repeating the matched transfer with the mask set, and again with stall clear, separates latching an event from stretching the clock.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
   typedef enum logic [2:0] {
      TS_IDLE, TS_ADDR, TS_AACK, TS_WDATA, TS_WACK, TS_RDATA, TS_RACK, TS_SKIP
   } tgt_state_e;

   // command word bit positions
   localparam int CMD_CLR_EVT  = 6;
   localparam int CMD_MASK_EVT = 4;
   localparam int CMD_ACK_EN   = 3;
   localparam int CMD_STALL    = 0;

   // event bits
   localparam int EVT_CMD  = 0;
   localparam int EVT_DATA = 1;

   // status bits
   localparam int ST_STOP = 5;
   localparam int ST_MACK = 3;
   localparam int ST_READ = 2;
endpackage

// File: rtl/i2c_tgt_sampler.sv
module i2c_tgt_sampler #(
   parameter int SYNC_STAGES = 2,
   parameter int FILTER_LEN  = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic level_o
);
   localparam int MSB = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
   end

   generate
      if (FILTER_LEN == 0) begin : g_direct
         assign level_o = sync_q[MSB];
      end else begin : g_filter
         localparam int CW = $clog2(FILTER_LEN + 1);
         logic [CW-1:0] run_q;
         logic          lvl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q <= '0;
               lvl_q <= 1'b1;
            end else if (sync_q[MSB] == lvl_q) begin
               run_q <= '0;
            end else if (run_q == CW'(FILTER_LEN)) begin
               lvl_q <= sync_q[MSB];
               run_q <= '0;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end
         assign level_o = lvl_q;
      end
   endgenerate
endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign scl_rise  = scl_i & ~scl_q;
   assign scl_fall  = ~scl_i & scl_q;
   assign start_det = scl_q & scl_i & sda_q & ~sda_i;
   assign stop_det  = scl_q & scl_i & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_tgt_hostif.sv
module i2c_tgt_hostif
   import i2c_tgt_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CMD_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_wr,
   input  logic [DATA_W-1:0] addr_d,
   input  logic              cmd_wr,
   input  logic [CMD_W-1:0]  cmd_d,
   input  logic              raise_cmd,
   input  logic              raise_data,
   input  logic              raise_stop,
   input  logic              rw_i,
   input  logic              mack_i,
   output logic [DATA_W-1:0] own_addr_o,
   output logic              ack_en_o,
   output logic              mask_o,
   output logic              stall_o,
   output logic [DATA_W-1:0] tx_byte_o,
   output logic [DATA_W-1:0] tx_new_o,
   output logic              tx_load_o,
   output logic              hold_o,
   output logic [1:0]        evt_o,
   output logic [DATA_W-1:0] stat_o
);
   localparam int TX_LSB = CMD_W - DATA_W;

   logic [DATA_W-1:0] own_q, tx_q;
   logic              ack_q, mask_q, stall_q, hold_q;
   logic [1:0]        evt_q, evt_n;
   logic              hold_n;
   logic              stop_q, read_q, mack_q;
   logic              clear, stretch_evt;
   logic              unused_cmd_bits;

   assign clear       = cmd_wr & cmd_d[CMD_CLR_EVT];
   assign stretch_evt = (raise_cmd & ~raise_stop) | raise_data;
   assign unused_cmd_bits = ^{cmd_d[TX_LSB-1], cmd_d[CMD_CLR_EVT-1], cmd_d[CMD_ACK_EN-1:CMD_STALL+1]};

   always_comb begin
      evt_n  = evt_q;
      hold_n = hold_q;
      if (clear) begin
         evt_n  = 2'b00;
         hold_n = 1'b0;
      end
      if (!mask_q) begin
         if (raise_cmd)  evt_n[EVT_CMD]  = 1'b1;
         if (raise_data) evt_n[EVT_DATA] = 1'b1;
         if (stall_q && stretch_evt) hold_n = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_q   <= '0;
         tx_q    <= '0;
         ack_q   <= 1'b0;
         mask_q  <= 1'b0;
         stall_q <= 1'b0;
         hold_q  <= 1'b0;
         evt_q   <= 2'b00;
         stop_q  <= 1'b0;
         read_q  <= 1'b0;
         mack_q  <= 1'b0;
      end else begin
         if (addr_wr) own_q <= addr_d;
         if (cmd_wr) begin
            tx_q    <= cmd_d[CMD_W-1:TX_LSB];
            ack_q   <= cmd_d[CMD_ACK_EN];
            mask_q  <= cmd_d[CMD_MASK_EVT];
            stall_q <= cmd_d[CMD_STALL];
         end
         evt_q  <= evt_n;
         hold_q <= hold_n;
         if (raise_cmd) begin
            stop_q <= raise_stop;
            if (!raise_stop) read_q <= rw_i;
         end
         if (raise_data) mack_q <= mack_i;
      end
   end

   always_comb begin
      stat_o          = '0;
      stat_o[ST_STOP] = stop_q;
      stat_o[ST_MACK] = mack_q;
      stat_o[ST_READ] = read_q;
   end

   assign own_addr_o = own_q;
   assign ack_en_o   = ack_q;
   assign mask_o     = mask_q;
   assign stall_o    = stall_q;
   assign tx_byte_o  = tx_q;
   assign tx_new_o   = cmd_d[CMD_W-1:TX_LSB];
   assign tx_load_o  = clear & hold_q;
   assign hold_o     = hold_q;
   assign evt_o      = evt_q;
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
   import i2c_tgt_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              sda_lvl,
   input  logic [DATA_W-1:0] own_addr,
   input  logic              ack_en,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic [DATA_W-1:0] tx_new,
   input  logic              tx_load,
   output logic              sda_oe,
   output logic              raise_cmd,
   output logic              raise_data,
   output logic              raise_stop,
   output logic              rw_o,
   output logic              mack_o,
   output logic [DATA_W-1:0] rx_o,
   output tgt_state_e        state_o
);
   localparam int CNT_W = $clog2(DATA_W + 1);

   tgt_state_e        state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] sh_q, tx_sh, rx_q;
   logic              rw_q, mack_q, active_q, ack_drv_q;
   logic              addr_hit, byte_done, bus_cond;

   assign addr_hit  = (own_addr != '0) && (sh_q[DATA_W-1:1] == own_addr[DATA_W-1:1]);
   assign byte_done = scl_fall && (cnt_q == CNT_W'(DATA_W));
   assign bus_cond  = start_det | stop_det;

   assign raise_stop = stop_det & active_q;
   assign raise_cmd  = raise_stop | ((state_q == TS_AACK) & scl_fall & ~bus_cond);
   assign raise_data = scl_fall & ~bus_cond & ((state_q == TS_WACK) | (state_q == TS_RACK));
   assign rw_o       = rw_q;
   assign mack_o     = (state_q == TS_RACK) & mack_q;
   assign rx_o       = rx_q;
   assign state_o    = state_q;

   always_comb begin
      unique case (state_q)
         TS_AACK:  sda_oe = 1'b1;
         TS_WACK:  sda_oe = ack_drv_q;
         TS_RDATA: sda_oe = ~tx_sh[DATA_W-1];
         default:  sda_oe = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= TS_IDLE;
         cnt_q     <= '0;
         sh_q      <= '0;
         tx_sh     <= '1;
         rx_q      <= '0;
         rw_q      <= 1'b0;
         mack_q    <= 1'b0;
         active_q  <= 1'b0;
         ack_drv_q <= 1'b0;
      end else if (start_det) begin
         state_q  <= TS_ADDR;
         cnt_q    <= '0;
         active_q <= 1'b0;
      end else if (stop_det) begin
         state_q  <= TS_IDLE;
         active_q <= 1'b0;
      end else begin
         unique case (state_q)
            TS_ADDR: begin
               if (scl_rise) begin
                  sh_q  <= {sh_q[DATA_W-2:0], sda_lvl};
                  cnt_q <= cnt_q + 1'b1;
               end else if (byte_done) begin
                  cnt_q <= '0;
                  if (addr_hit) begin
                     state_q  <= TS_AACK;
                     rw_q     <= sh_q[0];
                     active_q <= 1'b1;
                  end else begin
                     state_q <= TS_SKIP;
                  end
               end
            end
            TS_AACK: begin
               if (scl_fall) begin
                  cnt_q <= '0;
                  if (rw_q) begin
                     state_q <= TS_RDATA;
                     tx_sh   <= tx_byte;
                  end else begin
                     state_q <= TS_WDATA;
                  end
               end
            end
            TS_WDATA: begin
               if (scl_rise) begin
                  sh_q  <= {sh_q[DATA_W-2:0], sda_lvl};
                  cnt_q <= cnt_q + 1'b1;
               end else if (byte_done) begin
                  state_q   <= TS_WACK;
                  ack_drv_q <= ack_en;
                  cnt_q     <= '0;
               end
            end
            TS_WACK: begin
               if (scl_fall) begin
                  rx_q    <= sh_q;
                  state_q <= TS_WDATA;
               end
            end
            TS_RDATA: begin
               if (scl_fall) begin
                  if (cnt_q == CNT_W'(DATA_W - 1)) begin
                     state_q <= TS_RACK;
                     cnt_q   <= '0;
                  end else begin
                     tx_sh <= {tx_sh[DATA_W-2:0], 1'b1};
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            TS_RACK: begin
               if (scl_rise) begin
                  mack_q <= ~sda_lvl;
               end else if (scl_fall) begin
                  if (mack_q) begin
                     state_q <= TS_RDATA;
                     tx_sh   <= tx_byte;
                  end else begin
                     state_q <= TS_SKIP;
                  end
               end
            end
            default: ;
         endcase
         if (tx_load && state_q == TS_RDATA) tx_sh <= tx_new;
      end
   end
endmodule

// File: rtl/i2c_stall_target.sv
module i2c_stall_target
   import i2c_tgt_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FILTER_LEN  = 3,
   parameter int DATA_W      = 8,
   parameter int CMD_W       = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_oe,
   output logic              sda_oe,
   input  logic              own_addr_wr,
   input  logic [DATA_W-1:0] own_addr_d,
   input  logic              cmd_wr,
   input  logic [CMD_W-1:0]  cmd_d,
   output logic [1:0]        evt_o,
   output logic [DATA_W-1:0] stat_o,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              irq_o
);
   localparam int NLINES = 2;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (DATA_W != 8) begin : g_bad_width
         $error("DATA_W must be 8 for 7-bit addressing");
      end
      if (CMD_W != 2 * DATA_W) begin : g_bad_cmd
         $error("CMD_W must be twice DATA_W");
      end
   endgenerate

   logic [NLINES-1:0] raw_lines, lvl_lines;
   assign raw_lines = {sda_i, scl_i};

   generate
      for (genvar g = 0; g < NLINES; g++) begin : g_line
         i2c_tgt_sampler #(.SYNC_STAGES(SYNC_STAGES), .FILTER_LEN(FILTER_LEN)) u_smp (
            .clk(clk), .rst_n(rst_n), .line_i(raw_lines[g]), .level_o(lvl_lines[g])
         );
      end
   endgenerate

   logic scl_rise, scl_fall, start_det, stop_det;

   i2c_tgt_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_i(lvl_lines[0]), .sda_i(lvl_lines[1]),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
   );

   logic [DATA_W-1:0] own_addr, tx_byte, tx_new;
   logic              ack_en, evt_mask, evt_stall, tx_load, hold;
   logic              raise_cmd, raise_data, raise_stop, rw, mack;
   tgt_state_e        fsm_state;

   i2c_tgt_hostif #(.DATA_W(DATA_W), .CMD_W(CMD_W)) u_host (
      .clk(clk), .rst_n(rst_n),
      .addr_wr(own_addr_wr), .addr_d(own_addr_d),
      .cmd_wr(cmd_wr), .cmd_d(cmd_d),
      .raise_cmd(raise_cmd), .raise_data(raise_data), .raise_stop(raise_stop),
      .rw_i(rw), .mack_i(mack),
      .own_addr_o(own_addr), .ack_en_o(ack_en), .mask_o(evt_mask), .stall_o(evt_stall),
      .tx_byte_o(tx_byte), .tx_new_o(tx_new), .tx_load_o(tx_load), .hold_o(hold),
      .evt_o(evt_o), .stat_o(stat_o)
   );

   i2c_tgt_fsm #(.DATA_W(DATA_W)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
      .sda_lvl(lvl_lines[1]), .own_addr(own_addr), .ack_en(ack_en),
      .tx_byte(tx_byte), .tx_new(tx_new), .tx_load(tx_load),
      .sda_oe(sda_oe), .raise_cmd(raise_cmd), .raise_data(raise_data), .raise_stop(raise_stop),
      .rw_o(rw), .mack_o(mack), .rx_o(rx_data_o), .state_o(fsm_state)
   );

   assign scl_oe = hold;
   assign irq_o  = |evt_o;
endmodule

// File: rtl/i2c_stall_target_chk.sv
module i2c_stall_target_chk
   import i2c_tgt_pkg::*;
#(
   parameter int CMD_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             scl_oe,
   input logic             sda_oe,
   input logic             cmd_wr,
   input logic [CMD_W-1:0] cmd_d,
   input logic [1:0]       evt_o,
   input logic             irq_o,
   input logic             mask_q,
   input logic             stall_q,
   input tgt_state_e       state_q
);
   // R4: stretching only while an event is pending
   p_stretch_needs_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
      scl_oe |-> irq_o);

   // R4: a clearing command releases SCL and empties the events
   p_clear_releases_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && cmd_d[CMD_CLR_EVT] && scl_oe) |=> (!scl_oe && evt_o == 2'b00));

   // R10: masked events never appear
   p_mask_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q && evt_o == 2'b00) |=> (evt_o == 2'b00));

   // R11: no stretch starts while stall is off
   p_nostall_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall_q && !scl_oe) |=> !scl_oe);

   // R6: SDA is pulled only in ACK or transmit phases
   p_sda_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sda_oe |-> (state_q == TS_AACK || state_q == TS_WACK || state_q == TS_RDATA));
endmodule

bind i2c_stall_target i2c_stall_target_chk #(.CMD_W(CMD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe),
   .cmd_wr(cmd_wr), .cmd_d(cmd_d), .evt_o(evt_o), .irq_o(irq_o),
   .mask_q(evt_mask), .stall_q(evt_stall), .state_q(fsm_state)
);

// File: tb/tb_i2c_stall_target.sv
`timescale 1ns/1ps
module tb_i2c_stall_target;
   localparam int HP = 16;
   localparam logic [15:0] C_CLR   = 16'h0040;
   localparam logic [15:0] C_MASK  = 16'h0010;
   localparam logic [15:0] C_ACK   = 16'h0008;
   localparam logic [15:0] C_STALL = 16'h0001;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        m_scl_low = 1'b0, m_sda_low = 1'b0;
   logic        scl_line, sda_line;
   logic        scl_oe, sda_oe;
   logic        own_addr_wr = 1'b0;
   logic [7:0]  own_addr_d = '0;
   logic        cmd_wr = 1'b0;
   logic [15:0] cmd_d = '0;
   logic [1:0]  evt_o;
   logic [7:0]  stat_o, rx_data_o;
   logic        irq_o;
   int          checks = 0, errors = 0;

   always #4 clk = ~clk;

   assign scl_line = ~(m_scl_low | scl_oe);
   assign sda_line = ~(m_sda_low | sda_oe);

   i2c_stall_target dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
      .scl_oe(scl_oe), .sda_oe(sda_oe),
      .own_addr_wr(own_addr_wr), .own_addr_d(own_addr_d),
      .cmd_wr(cmd_wr), .cmd_d(cmd_d),
      .evt_o(evt_o), .stat_o(stat_o), .rx_data_o(rx_data_o), .irq_o(irq_o)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic host_cmd(input logic [15:0] w);
      @(negedge clk);
      cmd_d  = w;
      cmd_wr = 1'b1;
      @(negedge clk);
      cmd_wr = 1'b0;
   endtask

   task automatic set_addr(input logic [7:0] a);
      @(negedge clk);
      own_addr_d  = a;
      own_addr_wr = 1'b1;
      @(negedge clk);
      own_addr_wr = 1'b0;
   endtask

   task automatic bit_xfer(input logic b, output logic r);
      m_sda_low = ~b;
      wait_cyc(HP / 2);
      m_scl_low = 1'b0;
      while (!scl_line) @(negedge clk);
      wait_cyc(HP);
      r = sda_line;
      m_scl_low = 1'b1;
      wait_cyc(HP);
   endtask

   task automatic bus_start();
      m_sda_low = 1'b0;
      m_scl_low = 1'b0;
      wait_cyc(HP);
      m_sda_low = 1'b1;
      wait_cyc(HP);
      m_scl_low = 1'b1;
      wait_cyc(HP);
   endtask

   task automatic bus_stop();
      m_sda_low = 1'b1;
      wait_cyc(HP / 2);
      m_scl_low = 1'b0;
      while (!scl_line) @(negedge clk);
      wait_cyc(HP);
      m_sda_low = 1'b0;
      wait_cyc(HP);
   endtask

   task automatic send_byte(input logic [7:0] d, output logic ack);
      logic r;
      for (int i = 7; i >= 0; i--) bit_xfer(d[i], r);
      bit_xfer(1'b1, r);
      ack = ~r;
      wait_cyc(4);
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] d);
      logic r;
      for (int i = 7; i >= 0; i--) begin
         bit_xfer(1'b1, r);
         d[i] = r;
      end
      bit_xfer(~give_ack, r);
      wait_cyc(4);
   endtask

   task automatic t_reset();
      chk("R1 evt", {14'd0, evt_o}, 16'h0);
      chk("R1 irq", {15'd0, irq_o}, 16'h0);
      chk("R1 scl_oe", {15'd0, scl_oe}, 16'h0);
      chk("R1 sda_oe", {15'd0, sda_oe}, 16'h0);
   endtask

   task automatic t_write();
      logic ack;
      host_cmd(C_CLR | C_ACK | C_STALL);
      bus_start();
      send_byte(8'hA0, ack);
      chk("R2 addr ack", {15'd0, ack}, 16'h1);
      chk("R2 cmd event", {14'd0, evt_o}, 16'h1);
      chk("R2 stat write", {8'd0, stat_o & 8'h24}, 16'h0);
      chk("R4 stretch", {15'd0, scl_oe}, 16'h1);
      host_cmd(C_CLR | C_ACK | C_STALL);
      chk("R4 release", {15'd0, scl_oe}, 16'h0);
      chk("R4 cleared", {14'd0, evt_o}, 16'h0);
      send_byte(8'h3C, ack);
      chk("R6 acked", {15'd0, ack}, 16'h1);
      chk("R5 data event", {14'd0, evt_o}, 16'h2);
      chk("R5 rx byte", {8'd0, rx_data_o}, 16'h003C);
      host_cmd(C_CLR | C_STALL);
      send_byte(8'hC5, ack);
      chk("R6 nacked", {15'd0, ack}, 16'h0);
      chk("R5 rx byte2", {8'd0, rx_data_o}, 16'h00C5);
      host_cmd(C_CLR | C_STALL);
      bus_stop();
      wait_cyc(4);
      chk("R9 stop event", {14'd0, evt_o}, 16'h1);
      chk("R9 stop stat", {15'd0, stat_o[5]}, 16'h1);
      chk("R9 no stretch", {15'd0, scl_oe}, 16'h0);
      host_cmd(C_CLR | C_ACK | C_STALL);
   endtask

   task automatic t_read();
      logic       ack;
      logic [7:0] d;
      bus_start();
      send_byte(8'hA1, ack);
      chk("R2 read ack", {15'd0, ack}, 16'h1);
      chk("R2 stat read", {15'd0, stat_o[2]}, 16'h1);
      host_cmd(16'h9600 | C_CLR | C_ACK | C_STALL);
      recv_byte(1'b1, d);
      chk("R7 first byte", {8'd0, d}, 16'h0096);
      chk("R8 data event", {14'd0, evt_o}, 16'h2);
      chk("R8 master ack", {15'd0, stat_o[3]}, 16'h1);
      host_cmd(16'h5A00 | C_CLR | C_ACK | C_STALL);
      recv_byte(1'b0, d);
      chk("R7 second byte", {8'd0, d}, 16'h005A);
      chk("R8 master nack", {15'd0, stat_o[3]}, 16'h0);
      host_cmd(C_CLR | C_ACK | C_STALL);
      wait_cyc(4);
      chk("R8 sda released", {15'd0, sda_oe}, 16'h0);
      bus_stop();
      wait_cyc(4);
      chk("R9 stop after read", {14'd0, evt_o}, 16'h1);
      host_cmd(C_CLR | C_ACK | C_STALL);
   endtask

   task automatic t_mismatch();
      logic ack;
      bus_start();
      send_byte(8'h42, ack);
      chk("R3 nack other", {15'd0, ack}, 16'h0);
      chk("R3 no event", {14'd0, evt_o}, 16'h0);
      chk("R3 no stretch", {15'd0, scl_oe}, 16'h0);
      bus_stop();
      wait_cyc(4);
      chk("R3 silent stop", {14'd0, evt_o}, 16'h0);
   endtask

   task automatic t_disabled();
      logic ack;
      set_addr(8'h00);
      bus_start();
      send_byte(8'h00, ack);
      chk("R3 disabled nack", {15'd0, ack}, 16'h0);
      chk("R3 disabled evt", {14'd0, evt_o}, 16'h0);
      bus_stop();
      wait_cyc(4);
      chk("R3 disabled stop", {14'd0, evt_o}, 16'h0);
      set_addr(8'hA0);
   endtask

   task automatic t_mask();
      logic ack;
      host_cmd(C_CLR | C_ACK | C_STALL | C_MASK);
      bus_start();
      send_byte(8'hA0, ack);
      chk("R10 addr ack", {15'd0, ack}, 16'h1);
      chk("R10 no event", {14'd0, evt_o}, 16'h0);
      chk("R10 no stretch", {15'd0, scl_oe}, 16'h0);
      send_byte(8'h77, ack);
      chk("R10 data ack", {15'd0, ack}, 16'h1);
      chk("R10 rx", {8'd0, rx_data_o}, 16'h0077);
      chk("R10 no data evt", {14'd0, evt_o}, 16'h0);
      bus_stop();
      wait_cyc(4);
      chk("R10 no stop evt", {14'd0, evt_o}, 16'h0);
   endtask

   task automatic t_nostall();
      logic ack;
      host_cmd(C_CLR | C_ACK);
      bus_start();
      send_byte(8'hA0, ack);
      chk("R11 event", {14'd0, evt_o}, 16'h1);
      chk("R11 no stretch", {15'd0, scl_oe}, 16'h0);
      send_byte(8'h11, ack);
      chk("R11 accumulate", {14'd0, evt_o}, 16'h3);
      chk("R11 rx", {8'd0, rx_data_o}, 16'h0011);
      bus_stop();
      host_cmd(C_CLR | C_ACK | C_STALL);
      chk("R11 cleared", {14'd0, evt_o}, 16'h0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      wait_cyc(10);
      rst_n = 1'b1;
      wait_cyc(4);
      t_reset();
      set_addr(8'hA0);
      t_write();
      t_read();
      t_mismatch();
      t_disabled();
      t_mask();
      t_nostall();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule